// File: doc/BRIEF.md
# I/O Translation Unit Register Bank

This block holds the software-visible state of an I/O address-translation unit. A processor reaches it through a simple memory-mapped slave port that carries only whole 32-bit words. Each register keeps the bits that software may change and forces some bits high. A few registers are read-only or can only accumulate bits. The block sends three settings straight to the translator: the enable bit, the page-table base and the start address of the I/O window. It computes the window start from a 3-bit size code.

The translator reports faults through a one-cycle capture strobe, along with the faulting page address and the direction of the access. The block records the fault in its error status and error address registers and raises a level interrupt. That interrupt stays high until software reads or writes one of those two registers.

Top module: `iotx_regbank`

## Requirements
- R1: After reset the control register reads `{VERSION_ID, 24'h0}` and arbitration enable reads 0x00000008. Error status reads 0x00800000, arbiter enable reads 0x00000003 and mask ID reads 0x23000000. Every other register reads 0. `win_start` is 0 and `fault_irq` is low.
- R2: The word offsets are as follows: control 0x0000, table base 0x0004, full flush 0x0014, page flush 0x0018, error status 0x1000, error address 0x1004, arbiter enable 0x1008, slot configuration 0x1010, 0x1014, 0x1018 and 0x101C, arbitration enable 0x2000, mask ID 0x3018. An access to any other offset, or to an offset whose two low bits are not zero, reads 0 and its write changes nothing.
- R3: A control write keeps `wdata & 0x1D` in bits [4:0]. Bits [31:24] always read `VERSION_ID`. `xlate_en` follows bit 0.
- R4: A control write sets `win_start` from bits [4:2] (code k). The value is `0xFFFFFFFF << (24+k)`, so code 0 gives 0xFF000000 and code 7 gives 0x80000000.
- R5: The table base keeps `wdata & 0x07FFFC00` and drives `pt_base`. Each slot configuration keeps `wdata & 0x00010003`. Both flush registers and the error address keep all 32 bits.
- R6: Arbiter enable stores `(wdata & 0x801F000F) | 0x1`. Arbitration enable stores `(wdata & 0x001F0000) | 0x8`.
- R7: An error status write stores `(wdata & 0xFF0FFFFF) | 0x00800000`. A mask ID write ORs `wdata & 0x00FFFFFF` into the value already held.
- R8: A read or a write of error status or error address lowers `fault_irq` on the following clock edge.
- R9: A fault strobe sets error status to 0xC0820000, or to 0xC0860000 (bit 18 set) when the faulting access was a read. It loads error address with the page address and raises `fault_irq` on the next edge.
- R10: When a fault strobe and a software access to error status or error address fall in the same cycle, the fault wins. The fault values are stored and `fault_irq` ends high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| flt_strobe | input | 1 | Translator fault capture |
| flt_is_read | input | 1 | The faulting access was a read |
| flt_page | input | 32 | Faulting page address |
| xlate_en | output | 1 | Translation enable |
| pt_base | output | 32 | Page-table base register |
| win_start | output | 32 | Start address of the I/O window |
| fault_irq | output | 1 | Level fault interrupt |

## Verification
The assertions assume that each access lasts exactly one cycle with `bus_sel` high. They also assume that `flt_strobe` is a clean known level after reset. Interrupt properties that look one cycle ahead therefore depend only on the access and strobe seen at that edge. The bench drives every input on the falling edge and returns `bus_sel` to zero after each access. It raises the fault strobe only inside dedicated scenarios, so the effect of each strobe can be separated from the effect of a software access. Read data is sampled in the middle of the access cycle, before the read clears the interrupt.

// File: rtl/iotx_regbank.sv
module iotx_regbank #(
  parameter int          ADDR_W     = 14,
  parameter logic [7:0]  VERSION_ID = 8'h41,
  parameter logic [31:0] MASKID_RST = 32'h2300_0000,
  parameter int          N_SLOTS    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              flt_strobe,
  input  logic              flt_is_read,
  input  logic [31:0]       flt_page,
  output logic              xlate_en,
  output logic [31:0]       pt_base,
  output logic [31:0]       win_start,
  output logic              fault_irq
);
  localparam int IW = ADDR_W - 2;
  localparam logic [IW-1:0] I_CTRL  = IW'(12'h000);
  localparam logic [IW-1:0] I_BASE  = IW'(12'h001);
  localparam logic [IW-1:0] I_TFL   = IW'(12'h005);
  localparam logic [IW-1:0] I_PFL   = IW'(12'h006);
  localparam logic [IW-1:0] I_ESTAT = IW'(12'h400);
  localparam logic [IW-1:0] I_EADDR = IW'(12'h401);
  localparam logic [IW-1:0] I_ARBM  = IW'(12'h402);
  localparam logic [IW-1:0] I_SLOT0 = IW'(12'h404);
  localparam logic [IW-1:0] I_ARBEN = IW'(12'h800);
  localparam logic [IW-1:0] I_MSKID = IW'(12'hC06);
  localparam logic [31:0] ESTAT_FORCE = 32'h0080_0000;
  localparam logic [31:0] FAULT_BASE  = 32'hC082_0000;
  localparam logic [31:0] FAULT_RD    = 32'h0004_0000;

  logic [IW-1:0] idx;
  logic          aligned, wr, rd;
  logic [4:0]    ctrl_q;
  logic [31:0]   base_q, tfl_q, pfl_q, estat_q, eaddr_q, arbm_q, arben_q, mskid_q;
  logic [31:0]   slot_q [N_SLOTS];
  logic          err_touch;

  assign idx     = bus_addr[ADDR_W-1:2];
  assign aligned = bus_addr[1:0] == 2'b00;
  assign wr      = bus_sel && bus_we && aligned;
  assign rd      = bus_sel && !bus_we && aligned;
  assign err_touch = (wr || rd) && (idx == I_ESTAT || idx == I_EADDR);

  assign xlate_en = ctrl_q[0];
  assign pt_base  = base_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      win_start <= '0;
      base_q    <= '0;
      tfl_q     <= '0;
      pfl_q     <= '0;
      arbm_q    <= 32'h0000_0003;
      arben_q   <= 32'h0000_0008;
      mskid_q   <= MASKID_RST;
    end else if (wr) begin
      unique case (idx)
        I_CTRL: begin
          ctrl_q    <= bus_wdata[4:0] & 5'h1D;
          win_start <= 32'hFFFF_FFFF << (24 + int'(bus_wdata[4:2]));
        end
        I_BASE:  base_q  <= bus_wdata & 32'h07FF_FC00;
        I_TFL:   tfl_q   <= bus_wdata;
        I_PFL:   pfl_q   <= bus_wdata;
        I_ARBM:  arbm_q  <= (bus_wdata & 32'h801F_000F) | 32'h1;
        I_ARBEN: arben_q <= (bus_wdata & 32'h001F_0000) | 32'h8;
        I_MSKID: mskid_q <= mskid_q | (bus_wdata & 32'h00FF_FFFF);
        default: ;
      endcase
    end
  end

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        slot_q[s] <= '0;
      else if (wr && idx == I_SLOT0 + IW'(s))
        slot_q[s] <= bus_wdata & 32'h0001_0003;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      estat_q   <= ESTAT_FORCE;
      eaddr_q   <= '0;
      fault_irq <= 1'b0;
    end else if (flt_strobe) begin
      estat_q   <= FAULT_BASE | (flt_is_read ? FAULT_RD : 32'h0);
      eaddr_q   <= flt_page;
      fault_irq <= 1'b1;
    end else begin
      if (wr && idx == I_ESTAT) estat_q <= (bus_wdata & 32'hFF0F_FFFF) | ESTAT_FORCE;
      if (wr && idx == I_EADDR) eaddr_q <= bus_wdata;
      if (err_touch) fault_irq <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      unique case (idx)
        I_CTRL:  bus_rdata = {VERSION_ID, 19'h0, ctrl_q};
        I_BASE:  bus_rdata = base_q;
        I_TFL:   bus_rdata = tfl_q;
        I_PFL:   bus_rdata = pfl_q;
        I_ESTAT: bus_rdata = estat_q;
        I_EADDR: bus_rdata = eaddr_q;
        I_ARBM:  bus_rdata = arbm_q;
        I_ARBEN: bus_rdata = arben_q;
        I_MSKID: bus_rdata = mskid_q;
        default: begin
          for (int s = 0; s < N_SLOTS; s++)
            if (idx == I_SLOT0 + IW'(s)) bus_rdata = slot_q[s];
        end
      endcase
    end
  end

  p_fault_raises_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flt_strobe |=> fault_irq);
  p_fault_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_strobe && err_touch) |=> (fault_irq && estat_q[31]));
  p_touch_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_touch && !flt_strobe) |=> !fault_irq);
  p_irq_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_irq && !err_touch && !flt_strobe) |=> fault_irq);
  p_win_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (win_start != 32'h0) |-> (win_start[31] && win_start[23:0] == 24'h0));
  p_win_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && idx == I_CTRL) |=> $stable(win_start));
  p_estat_forced_r7: assert property (@(posedge clk) disable iff (!rst_n)
    estat_q[23]);
  p_maskid_grows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(mskid_q) & ~mskid_q) == 32'h0));
endmodule

// File: tb/iotx_regbank_bench.sv
module iotx_regbank_bench;
  localparam logic [7:0] VER = 8'h41;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 0, bus_we = 0, flt_strobe = 0, flt_is_read = 0;
  logic [13:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, flt_page = '0;
  logic [31:0] bus_rdata, pt_base, win_start;
  logic xlate_en, fault_irq;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  iotx_regbank #(.VERSION_ID(VER)) u_iotx_regbank (
    .clk, .rst_n, .bus_sel, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
    .flt_strobe, .flt_is_read, .flt_page, .xlate_en, .pt_base, .win_start, .fault_irq);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [13:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(logic [13:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic rd_chk(string req, logic [13:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic fault(logic is_rd, logic [31:0] pg);
    @(negedge clk);
    flt_strobe = 1; flt_is_read = is_rd; flt_page = pg;
    @(negedge clk);
    flt_strobe = 0;
  endtask

  task automatic t_reset_r1;
    rd_chk("R1 ctrl", 14'h0000, {VER, 24'h0});
    rd_chk("R1 arben", 14'h2000, 32'h8);
    rd_chk("R1 estat", 14'h1000, 32'h0080_0000);
    rd_chk("R1 arbm", 14'h1008, 32'h3);
    rd_chk("R1 maskid", 14'h3018, 32'h2300_0000);
    rd_chk("R1 base", 14'h0004, 32'h0);
    chk("R1 win", win_start, 32'h0);
    chk("R1 irq", {31'h0, fault_irq}, 32'h0);
  endtask

  task automatic t_ctrl_r3_r4;
    wr(14'h0000, 32'hFFFF_FFE3);
    rd_chk("R3 ctrl mask", 14'h0000, {VER, 24'h01});
    chk("R3 enable", {31'h0, xlate_en}, 32'h1);
    chk("R4 code0", win_start, 32'hFF00_0000);
    wr(14'h0000, 32'h0000_001C);
    chk("R4 code7", win_start, 32'h8000_0000);
    chk("R3 disable", {31'h0, xlate_en}, 32'h0);
    wr(14'h0000, 32'h0000_000C);
    chk("R4 code3", win_start, 32'hF800_0000);
  endtask

  task automatic t_masks_r5_r6;
    wr(14'h0004, 32'hFFFF_FFFF);
    rd_chk("R5 base", 14'h0004, 32'h07FF_FC00);
    chk("R5 pt_base", pt_base, 32'h07FF_FC00);
    for (int s = 0; s < 4; s++) wr(14'h1010 + 14'(4*s), 32'hFFFF_FFF0 | 32'(s));
    for (int s = 0; s < 4; s++)
      rd_chk("R5 slot", 14'h1010 + 14'(4*s), 32'h0001_0000 | 32'(s & 3));
    wr(14'h0014, 32'hDEAD_BEEF);
    rd_chk("R5 tflush", 14'h0014, 32'hDEAD_BEEF);
    wr(14'h0018, 32'h1234_5678);
    rd_chk("R5 pflush", 14'h0018, 32'h1234_5678);
    wr(14'h1008, 32'h0);
    rd_chk("R6 arbm zero", 14'h1008, 32'h1);
    wr(14'h1008, 32'hFFFF_FFFF);
    rd_chk("R6 arbm ones", 14'h1008, 32'h801F_000F);
    wr(14'h2000, 32'hFFFF_FFFF);
    rd_chk("R6 arben", 14'h2000, 32'h001F_0008);
  endtask

  task automatic t_estat_maskid_r7;
    wr(14'h1000, 32'hFFFF_FFFF);
    rd_chk("R7 estat ones", 14'h1000, 32'hFF8F_FFFF);
    wr(14'h1000, 32'h0);
    rd_chk("R7 estat zero", 14'h1000, 32'h0080_0000);
    wr(14'h3018, 32'hFF00_0011);
    rd_chk("R7 maskid or", 14'h3018, 32'h2300_0011);
    wr(14'h3018, 32'h0000_0100);
    rd_chk("R7 maskid keep", 14'h3018, 32'h2300_0111);
  endtask

  task automatic t_unmapped_r2;
    wr(14'h0008, 32'hFFFF_FFFF);
    rd_chk("R2 unmapped", 14'h0008, 32'h0);
    wr(14'h0005, 32'h0000_0000);
    rd_chk("R2 misaligned wr", 14'h0004, 32'h07FF_FC00);
    rd_chk("R2 misaligned rd", 14'h0005, 32'h0);
    wr(14'h1004, 32'hCAFE_F00D);
    rd_chk("R2 eaddr", 14'h1004, 32'hCAFE_F00D);
  endtask

  task automatic t_fault_r8_r9;
    logic [31:0] v;
    fault(1'b1, 32'h8123_4000);
    chk("R9 irq up", {31'h0, fault_irq}, 32'h1);
    rd(14'h1000, v);
    chk("R9 estat read", v, 32'hC086_0000);
    chk("R8 read clears", {31'h0, fault_irq}, 32'h0);
    rd_chk("R9 eaddr", 14'h1004, 32'h8123_4000);
    fault(1'b0, 32'h9000_0000);
    rd_chk("R9 estat write-fault", 14'h1000, 32'hC082_0000);
    fault(1'b0, 32'h9000_1000);
    wr(14'h1004, 32'h0);
    chk("R8 write clears", {31'h0, fault_irq}, 32'h0);
    fault(1'b0, 32'h9000_2000);
    rd_chk("R8 other reg no clear", 14'h0000, {VER, 24'h0C});
    chk("R8 irq kept", {31'h0, fault_irq}, 32'h1);
    rd(14'h1004, v);
  endtask

  task automatic t_priority_r10;
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = 14'h1000; bus_wdata = 32'h0;
    flt_strobe = 1; flt_is_read = 0; flt_page = 32'hA000_0000;
    @(negedge clk);
    bus_sel = 0; bus_we = 0; flt_strobe = 0;
    chk("R10 irq", {31'h0, fault_irq}, 32'h1);
    @(negedge clk);
    bus_sel = 1; bus_addr = 14'h1000;
    #1 chk("R10 estat", bus_rdata, 32'hC082_0000);
    @(negedge clk);
    bus_sel = 0;
    rd_chk("R10 eaddr", 14'h1004, 32'hA000_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset_r1();
    t_ctrl_r3_r4();
    t_masks_r5_r6();
    t_estat_maskid_r7();
    t_unmapped_r2();
    t_fault_r8_r9();
    t_priority_r10();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule